// File: doc/BRIEF.md
# BCD Calendar Counter with Hold Handshake

This block keeps wall-clock time and date as packed BCD fields: seconds, minutes, hours, weekday, day of month, month and a two-digit year for 2000 to 2099. A one-cycle `slow_tick` strobe marks each edge of a 32.768 kHz reference. Every `TICKS_PER_SEC` strobes advance the seconds field by one, and carries move on through the rest of the calendar. Month lengths follow the leap-year rule for that century.

Software uses a small byte-addressed register port. A control register turns counting on and picks between 24-hour and 12-hour hour coding. A hold register carries a request bit and a status bit. To set the clock, software raises the request, which stops counting at once. It then polls for the status bit, which rises on the second slow tick after the request. Only then does it write the time fields. Writing zero to the hold register releases the counter, which goes on from the values just loaded.

Reads of the time go to a separate snapshot copy of the fields. The snapshot takes the new value at every second boundary and at every load. Software can read the seconds field again to detect a read that crossed a tick.

Top module: `cal_bcd_counter`

## Requirements
- R1: After reset, counting is off, 12-hour coding is selected, the hold register reads 0x00 and the snapshot reads 00 s, 00 min, hour 0x12 (12 AM), weekday 6, day 0x01, month 0x01, year 0x00.
- R2: Register 0x00 has enable at bit 7 and 24-hour select at bit 5, and reads back only those bits. The seconds field advances only while enable is set and no hold is pending. It advances on exactly every `TICKS_PER_SEC`-th slow tick.
- R3: Seconds and minutes go from 0x59 to 0x00 and carry. Hours go from 0x23 to 0x00 (24-hour coding) and carry into day and weekday. Every field steps in BCD, so 0x09 is followed by 0x10.
- R4: The day goes to 0x01 after the last day of the month and carries into the month. The last day is 0x30 for months 4, 6, 9 and 11, 0x31 for the other months, and 0x29 in February when the year is a multiple of 4 (0x28 otherwise). Month 0x12 wraps to 0x01 and increments the year. Year 0x99 wraps to 0x00. Weekday counts 0 to 6 (Sunday = 0) and wraps 6 to 0 with every day carry.
- R5: Register 0x08 has the request at bit 0 and the read-only status at bit 1. Counting stops in the cycle after the request is written. Status stays 0 after the first slow tick that follows and reads 1 after the second.
- R6: Writes to the time fields change nothing unless status is set. The write offsets are 0x14 seconds, 0x18 minutes, 0x1C hours, 0x20 weekday, 0x24 day, 0x28 month and 0x2C year.
- R7: Writing zero to register 0x08 clears request and status together. Counting then goes on from the loaded values, and the first second after release takes a full `TICKS_PER_SEC` slow ticks.
- R8: With bit 5 of register 0x00 clear, the hour is read and written as 12-hour BCD 0x01 to 0x12 in bits 4:0, with bit 5 = PM. With bit 5 set, it is plain BCD 0x00 to 0x23.
- R9: The snapshot fields are at 0x4C, 0x50, 0x54, 0x58, 0x5C, 0x60 and 0x64, in the same field order as the write offsets. They take the new time in the same clock edge as a second advance or a field load, and stay unchanged otherwise. Unmapped offsets read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_tick | input | 1 | One-cycle strobe per 32.768 kHz edge |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte offset of the register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from `reg_addr` |

## Verification
Register writes take effect at the clock edge where `reg_wr` is sampled. Read data follows `reg_addr` in the same cycle. For this reason the bench drives on the falling edge and samples one nanosecond after setting an address, with no pipeline to allow for. A second advance, and its snapshot copy, appears right after the edge that samples the `TICKS_PER_SEC`-th strobe. The bench counts strobes exactly and samples the seconds field both one strobe before that boundary and right after it. The status bit is checked after the first and after the second strobe following a request.

// File: rtl/cal_pkg.sv
package cal_pkg;
  typedef struct packed {
    logic [7:0] sec;
    logic [7:0] min;
    logic [7:0] hour;
    logic [7:0] wday;
    logic [7:0] day;
    logic [7:0] mon;
    logic [7:0] year;
  } cal_time_t;

  localparam int unsigned NUM_FIELDS = 7;
  localparam int unsigned OFS_CTRL   = 'h00;
  localparam int unsigned OFS_HOLD   = 'h08;
  localparam int unsigned OFS_WR     = 'h14;
  localparam int unsigned OFS_RD     = 'h4C;

  function automatic logic [6:0] bcd2bin(input logic [7:0] v);
    return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
  endfunction

  function automatic logic [7:0] bin2bcd(input logic [6:0] b);
    return {4'(b / 7'd10), 4'(b % 7'd10)};
  endfunction

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    return (v[3:0] >= 4'd9) ? {v[7:4] + 4'd1, 4'd0} : v + 8'd1;
  endfunction

  function automatic logic leap_year(input logic [7:0] y);
    return y[4] ? (y[3:0] == 4'd2 || y[3:0] == 4'd6)
                : (y[3:0] == 4'd0 || y[3:0] == 4'd4 || y[3:0] == 4'd8);
  endfunction

  function automatic logic [7:0] month_end(input logic [7:0] m, input logic [7:0] y);
    case (m)
      8'h02: return leap_year(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default: return 8'h31;
    endcase
  endfunction

  function automatic logic [7:0] hour_to12(input logic [7:0] h24);
    logic [6:0] b;
    logic [6:0] r;
    b = bcd2bin(h24);
    r = (b >= 7'd12) ? b - 7'd12 : b;
    if (r == 7'd0) r = 7'd12;
    return bin2bcd(r) | ((b >= 7'd12) ? 8'h20 : 8'h00);
  endfunction

  function automatic logic [7:0] hour_to24(input logic [7:0] h12);
    logic [6:0] b;
    b = bcd2bin({3'b000, h12[4:0]});
    if (b == 7'd12) b = 7'd0;
    return bin2bcd(b + (h12[5] ? 7'd12 : 7'd0));
  endfunction
endpackage

// File: rtl/cal_tick_div.sv
module cal_tick_div #(
  parameter int unsigned DIV = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic run,
  input  logic clear,
  output logic adv
);
  localparam int unsigned W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt;

  assign adv = run && tick && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) cnt <= '0;
    else if (run && tick) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/cal_hold_ctl.sv
module cal_hold_ctl #(
  parameter int unsigned SETTLE = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic wr,
  input  logic wbit,
  output logic req,
  output logic stat
);
  localparam int unsigned CW = $clog2(SETTLE + 1);
  localparam logic [CW-1:0] LAST = CW'(SETTLE - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req  <= 1'b0;
      stat <= 1'b0;
      cnt  <= '0;
    end else if (wr) begin
      req <= wbit;
      if (!wbit) begin
        stat <= 1'b0;
        cnt  <= '0;
      end
    end else if (req && !stat && tick) begin
      if (cnt == LAST) stat <= 1'b1;
      else cnt <= cnt + 1'b1;
    end
  end

  // R5: status is never set without a pending request
  a_r5_stat_needs_req: assert property (@(posedge clk) disable iff (!rst_n) stat |-> req);
  // R5: status rises only on a slow tick
  a_r5_stat_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat) |-> $past(tick));
endmodule

// File: rtl/cal_advance.sv
module cal_advance
  import cal_pkg::*;
(
  input  cal_time_t cur,
  output cal_time_t nxt
);
  logic [7:0] last_day;
  assign last_day = month_end(cur.mon, cur.year);

  always_comb begin
    nxt = cur;
    if (cur.sec != 8'h59) nxt.sec = bcd_inc(cur.sec);
    else begin
      nxt.sec = 8'h00;
      if (cur.min != 8'h59) nxt.min = bcd_inc(cur.min);
      else begin
        nxt.min = 8'h00;
        if (cur.hour != 8'h23) nxt.hour = bcd_inc(cur.hour);
        else begin
          nxt.hour = 8'h00;
          nxt.wday = (cur.wday >= 8'd6) ? 8'd0 : cur.wday + 8'd1;
          if (cur.day != last_day) nxt.day = bcd_inc(cur.day);
          else begin
            nxt.day = 8'h01;
            if (cur.mon != 8'h12) nxt.mon = bcd_inc(cur.mon);
            else begin
              nxt.mon  = 8'h01;
              nxt.year = (cur.year == 8'h99) ? 8'h00 : bcd_inc(cur.year);
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/cal_hour_fmt.sv
module cal_hour_fmt
  import cal_pkg::*;
#(
  parameter bit TO_12H = 1'b1
) (
  input  logic       mode24,
  input  logic [7:0] hin,
  output logic [7:0] hout
);
  generate
    if (TO_12H) begin : g_to12
      assign hout = mode24 ? hin : hour_to12(hin);
    end else begin : g_to24
      assign hout = mode24 ? hin : hour_to24(hin);
    end
  endgenerate
endmodule

// File: rtl/cal_bcd_counter.sv
module cal_bcd_counter
  import cal_pkg::*;
#(
  parameter int unsigned TICKS_PER_SEC = 32768,
  parameter int unsigned SETTLE_TICKS  = 2,
  parameter int unsigned ADDR_W        = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_tick,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_HOLD = ADDR_W'(OFS_HOLD);

  localparam cal_time_t RESET_TIME = '{sec: 8'h00, min: 8'h00, hour: 8'h00,
                                       wday: 8'd6, day: 8'h01, mon: 8'h01, year: 8'h00};

  logic      en_q, m24_q;
  logic      hold_req, hold_stat;
  logic      adv, load;
  cal_time_t live, live_nxt, snap, stepped;
  logic [7:0] hour_in24, hour_out;
  logic [NUM_FIELDS-1:0] wr_hit, rd_hit;

  // address decode per field, one comparator each
  generate
    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_dec
      assign wr_hit[i] = (reg_addr == ADDR_W'(OFS_WR + 4 * i));
      assign rd_hit[i] = (reg_addr == ADDR_W'(OFS_RD + 4 * i));
    end
  endgenerate

  assign load = reg_wr && hold_stat && (|wr_hit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      m24_q <= 1'b0;
    end else if (reg_wr && reg_addr == A_CTRL) begin
      en_q  <= reg_wdata[7];
      m24_q <= reg_wdata[5];
    end
  end

  cal_hold_ctl #(.SETTLE(SETTLE_TICKS)) u_hold (
    .clk(clk), .rst_n(rst_n), .tick(slow_tick),
    .wr(reg_wr && reg_addr == A_HOLD), .wbit(reg_wdata[0]),
    .req(hold_req), .stat(hold_stat)
  );

  cal_tick_div #(.DIV(TICKS_PER_SEC)) u_div (
    .clk(clk), .rst_n(rst_n), .tick(slow_tick),
    .run(en_q && !hold_req && !hold_stat),
    .clear(hold_req || hold_stat), .adv(adv)
  );

  cal_advance u_adv (.cur(live), .nxt(stepped));

  cal_hour_fmt #(.TO_12H(1'b0)) u_hin  (.mode24(m24_q), .hin(reg_wdata), .hout(hour_in24));
  cal_hour_fmt #(.TO_12H(1'b1)) u_hout (.mode24(m24_q), .hin(snap.hour), .hout(hour_out));

  always_comb begin
    live_nxt = adv ? stepped : live;
    if (load) begin
      if (wr_hit[0]) live_nxt.sec  = reg_wdata;
      if (wr_hit[1]) live_nxt.min  = reg_wdata;
      if (wr_hit[2]) live_nxt.hour = hour_in24;
      if (wr_hit[3]) live_nxt.wday = reg_wdata;
      if (wr_hit[4]) live_nxt.day  = reg_wdata;
      if (wr_hit[5]) live_nxt.mon  = reg_wdata;
      if (wr_hit[6]) live_nxt.year = reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live <= RESET_TIME;
      snap <= RESET_TIME;
    end else begin
      live <= live_nxt;
      if (adv || load) snap <= live_nxt;
    end
  end

  always_comb begin
    reg_rdata = 8'h00;
    if (reg_addr == A_CTRL) reg_rdata = {en_q, 1'b0, m24_q, 5'b0};
    if (reg_addr == A_HOLD) reg_rdata = {6'b0, hold_stat, hold_req};
    if (rd_hit[0]) reg_rdata = snap.sec;
    if (rd_hit[1]) reg_rdata = snap.min;
    if (rd_hit[2]) reg_rdata = hour_out;
    if (rd_hit[3]) reg_rdata = snap.wday;
    if (rd_hit[4]) reg_rdata = snap.day;
    if (rd_hit[5]) reg_rdata = snap.mon;
    if (rd_hit[6]) reg_rdata = snap.year;
  end

  // R2: seconds move only after an advance or a load
  a_r2_sec_only_on_event: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !load) |=> $stable(live.sec));
  // R6: without status the time state cannot be changed except by counting
  a_r6_no_change_unheld: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_stat && !adv) |=> $stable(live));
  // R9: the snapshot tracks the live time after every advance or load
  a_r9_snap_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (adv || load) |=> (snap == live));
  // R5: no advance while held
  a_r5_no_adv_held: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_req || hold_stat) |=> $stable(snap.sec) || $past(load));
endmodule

// File: tb/cal_bcd_counter_test.sv
module cal_bcd_counter_test;
  localparam int T = 4;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       slow_tick = 0;
  logic       reg_wr = 0;
  logic [6:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;

  int total = 0, bad = 0;
  bit done = 0;
  int my, mmo, md, mwd, mh, mmi, ms;
  bit m24;

  always #10 clk = ~clk;

  cal_bcd_counter #(.TICKS_PER_SEC(T)) uut (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  function automatic logic [7:0] bcd(int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int dim(int m, int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] hour_code(int h, bit mode);
    int r;
    if (mode) return bcd(h);
    r = h % 12;
    if (r == 0) r = 12;
    return bcd(r) | ((h >= 12) ? 8'h20 : 8'h00);
  endfunction

  task automatic model_step();
    ms++;
    if (ms < 60) return;
    ms = 0; mmi++;
    if (mmi < 60) return;
    mmi = 0; mh++;
    if (mh < 24) return;
    mh = 0; mwd = (mwd + 1) % 7; md++;
    if (md <= dim(mmo, my)) return;
    md = 1; mmo++;
    if (mmo <= 12) return;
    mmo = 1; my = (my + 1) % 100;
  endtask

  task automatic wr(int a, logic [7:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = 7'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(int a, output logic [7:0] v);
    @(negedge clk);
    reg_addr = 7'(a);
    #1 v = reg_rdata;
  endtask

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic rd_chk(string tag, int a, logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic tick();
    @(negedge clk) slow_tick = 1;
    @(negedge clk) slow_tick = 0;
  endtask

  task automatic secs(int n);
    for (int i = 0; i < n; i++) begin
      repeat (T) tick();
      model_step();
    end
  endtask

  task automatic chk_all(string tag);
    rd_chk(tag, 'h4C, bcd(ms));
    rd_chk(tag, 'h50, bcd(mmi));
    rd_chk(tag, 'h54, hour_code(mh, m24));
    rd_chk(tag, 'h58, 8'(mwd));
    rd_chk(tag, 'h5C, bcd(md));
    rd_chk(tag, 'h60, bcd(mmo));
    rd_chk(tag, 'h64, bcd(my));
  endtask

  task automatic load(int y, int mo, int d, int wd, int h, int mi, int s);
    wr('h08, 8'h01);
    tick(); tick();
    wr('h14, bcd(s));  wr('h18, bcd(mi)); wr('h1C, hour_code(h, m24));
    wr('h20, 8'(wd));  wr('h24, bcd(d));  wr('h28, bcd(mo)); wr('h2C, bcd(y));
    my = y; mmo = mo; md = d; mwd = wd; mh = h; mmi = mi; ms = s;
    wr('h08, 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd2024);
    my = 0; mmo = 1; md = 1; mwd = 6; mh = 0; mmi = 0; ms = 0; m24 = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    chk_all("R1");
    rd_chk("R1", 'h00, 8'h00);
    rd_chk("R1", 'h08, 8'h00);
    rd_chk("R9 unmapped", 'h30, 8'h00);

    // R2 disabled counter ignores ticks
    repeat (3 * T) tick();
    rd_chk("R2 disabled", 'h4C, 8'h00);

    // R2 enable, 24-hour mode, exact tick count
    wr('h00, 8'hFF); m24 = 1;
    rd_chk("R2 ctrl readback", 'h00, 8'hA0);
    repeat (T - 1) tick();
    rd_chk("R2 before boundary", 'h4C, 8'h00);
    tick(); model_step();
    rd_chk("R9 after boundary", 'h4C, 8'h01);

    // R5/R6 hold handshake and ignored writes
    wr('h14, 8'h40);
    rd_chk("R6 unheld write", 'h4C, 8'h01);
    wr('h08, 8'h01);
    tick();
    rd_chk("R5 one tick", 'h08, 8'h01);
    wr('h14, 8'h40);
    tick();
    rd_chk("R5 two ticks", 'h08, 8'h03);
    repeat (2 * T) tick();
    rd_chk("R5 held", 'h4C, 8'h01);
    wr('h08, 8'h00);
    rd_chk("R7 release", 'h08, 8'h00);
    repeat (T - 1) tick();
    rd_chk("R7 full second", 'h4C, 8'h01);
    tick(); model_step();
    rd_chk("R6 write was ignored", 'h4C, 8'h02);

    // R3/R4 directed corners
    load(4, 2, 28, 6, 23, 59, 58);
    rd_chk("R9 load copies", 'h4C, 8'h58);
    secs(2); chk_all("R4 leap Feb 29");
    load(3, 2, 28, 5, 23, 59, 59);
    secs(1); chk_all("R4 Feb 28 to Mar 1");
    load(99, 12, 31, 6, 23, 59, 59);
    secs(1); chk_all("R4 century wrap");
    load(10, 4, 30, 3, 23, 59, 59);
    secs(1); chk_all("R4 30-day month");
    load(10, 5, 9, 2, 9, 9, 9);
    secs(1); chk_all("R3 BCD digit carry");

    // R8 12-hour coding
    wr('h00, 8'h80); m24 = 0;
    load(20, 6, 15, 1, 23, 59, 59);
    rd_chk("R8 PM readback", 'h54, 8'h31);
    secs(1); chk_all("R8 midnight 12 AM");
    load(20, 6, 15, 1, 11, 59, 59);
    secs(1);
    rd_chk("R8 noon", 'h54, 8'h32);
    wr('h00, 8'hA0); m24 = 1;
    rd_chk("R8 noon in 24h", 'h54, 8'h12);

    // R3/R4 constrained random near rollovers
    for (int it = 0; it < 30; it++) begin
      int y, mo, d;
      y  = $urandom_range(0, 99);
      mo = $urandom_range(1, 12);
      d  = dim(mo, y) - $urandom_range(0, 1);
      load(y, mo, d, $urandom_range(0, 6),
           ($urandom_range(0, 1) != 0) ? 23 : $urandom_range(0, 23),
           ($urandom_range(0, 1) != 0) ? 59 : $urandom_range(0, 59),
           $urandom_range(50, 59));
      secs($urandom_range(1, 12));
      chk_all("R3/R4 random");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule